// File: doc/BRIEF.md
# Hexadecimal Floating-Point Digit Shifter

This unit takes one base-16 floating-point word and moves its fraction by whole hexadecimal digits, one digit per clock. A word is a sign bit at the top, a 7-bit characteristic (exponent) below it, and a fraction in the remaining low bits. The short format is 32 bits wide with a 24-bit fraction. The long format is 64 bits wide with a 56-bit fraction.

A 7-bit two's-complement digit count picks both the direction and the distance of the shift. A count of zero or more is a left shift, and the unit then acts as a normalizer with a step limit. It stops as soon as the fraction is normalized, when the characteristic underflows, or when the count runs out, whichever comes first. A negative count is a right shift by the magnitude of the count.

A negative operand is handled as its magnitude, and the result is negated again at the end. The caller pulses `start` with the operand, the format and the count. It then waits for the one-cycle `done` pulse, when the result and the two condition flags are valid. The result and the flags hold their values until the next operation completes.

Top module: `hex_fp_shifter`

## Requirements
- R1: Format and result layout. With `fmtLong`=1 the word is `operandIn[63:0]`, with sign at bit 63, characteristic at bits 62:56 and fraction at bits 55:0. With `fmtLong`=0 the word is `operandIn[31:0]`, with sign at bit 31, characteristic at bits 30:24 and fraction at bits 23:0. In the short format, `resultOut[63:32]` is zero.
- R2: `countIn` is two's complement. A value of 0 to 63 requests a left shift of that many digits at most. A value of -1 to -64 requests a right shift of exactly that many digits.
- R3: If the sign bit of the operand is 1, the word is two's complemented within its format width before it is split into characteristic and fraction. The reassembled result (sign 0, characteristic, fraction) is two's complemented again before it is output.
- R4: Both flags are cleared when an operation begins. `cc1` is 1 after a left shift exactly when the fraction was zero, or its top hex digit was nonzero, before any step was taken. `cc1` is always 0 after a right shift.
- R5: On a left shift with an all-zero fraction, the result is all zeros whatever the sign and characteristic were, and no step is taken.
- R6: Each left step moves the fraction one digit (4 bits) up, fills the low digit with zeros, and decrements the characteristic by 1. Stepping ends when the top digit is nonzero or when `countIn` steps have been made.
- R7: A left step that decrements a characteristic of 0 yields 127. This sets `cc2` to 1 and ends the operation after that step. `cc1` and `cc2` are never both 1.
- R8: Each right step moves the fraction one digit down, fills the top digit with zeros, drops the low digit, and increments the characteristic modulo 128. `cc2` stays 0.
- R9: Let the operation be accepted at clock edge 0, and let n be the number of steps taken. `done` is 1 for exactly one cycle, after edge n+1. After an underflow it comes instead after edge n.
- R10: A `start` while an operation is in progress is ignored. The running operation's result, flags and timing are unaffected, and no extra `done` appears.
- R11: After reset, `done`, `cc1`, `cc2` and `resultOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation when the unit is idle |
| fmtLong | input | 1 | 1 selects the 64-bit format, 0 the 32-bit format |
| operandIn | input | 64 | Floating-point word (short format uses bits 31:0) |
| countIn | input | 7 | Signed digit count |
| resultOut | output | 64 | Shifted word, valid when `done` is 1 and held afterwards |
| cc1 | output | 1 | Fraction was already normalized or zero (left shifts) |
| cc2 | output | 1 | Characteristic underflowed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the points where a left shift must stop. These are a fraction that is already normalized, a count of zero, a count that runs out before normalization, and a characteristic that wraps from 0 to 127 partway through. A design that checks its stop conditions in the wrong order would take one step too many or too few. That shows up as a wrong characteristic and a `done` one cycle off. Zero fractions with a set sign and a nonzero characteristic must come back as all zeros; a design that only clears the fraction would leak those fields. Negative operands, right shifts up to 64 digits with characteristic wrap, the short format's cleared upper half, and a `start` raised mid-operation each expose a missing negation, a leaked digit, a stale upper word or a restarted sequence.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

  // strobes from the sequencer to the datapath, valid for one cycle each
  typedef struct packed {
    logic load;       // capture operand, clear flags
    logic stepLeft;   // one digit up, characteristic minus one
    logic stepRight;  // one digit down, characteristic plus one
    logic finish;     // write result, raise done
    logic markNorm;   // set cc1
    logic forceZero;  // result becomes a true zero
  } hfsCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hfsState_t;

endpackage

// File: rtl/hfs_lane.sv
// Unpack/pack for one word format: magnitude on entry, re-signed on exit.
module hfs_lane #(
  parameter int CHAR_W = 7,
  parameter int FRAC_W = 24
) (
  input  logic [1+CHAR_W+FRAC_W-1:0] operandIn,
  input  logic [CHAR_W-1:0]          packChar,
  input  logic [FRAC_W-1:0]          packFrac,
  input  logic                       packNeg,
  output logic                       unpSign,
  output logic [CHAR_W-1:0]          unpChar,
  output logic [FRAC_W-1:0]          unpFrac,
  output logic [1+CHAR_W+FRAC_W-1:0] packWord
);
  localparam int W = 1 + CHAR_W + FRAC_W;
  localparam logic [W-1:0] ONE_W = W'(1);

  logic [W-1:0] magWord;
  logic [W-1:0] rawWord;

  always_comb begin
    unpSign  = operandIn[W-1];
    magWord  = unpSign ? (~operandIn + ONE_W) : operandIn;
    unpChar  = magWord[W-2 -: CHAR_W];
    unpFrac  = magWord[FRAC_W-1:0];
    rawWord  = {1'b0, packChar, packFrac};
    packWord = packNeg ? (~rawWord + ONE_W) : rawWord;
  end
endmodule

// File: rtl/hfs_ctrl.sv
// Sequencer: decides per cycle whether to step, in which direction, or stop.
module hfs_ctrl
  import hfs_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] countIn,
  input  logic             fracZero,
  input  logic             fracNorm,
  input  logic             charZero,
  output hfsCtrl_t         ctl
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  hfsState_t        state;
  logic             goRight;
  logic             firstStep;
  logic [CNT_W-1:0] remaining;
  logic             countNeg;
  logic [CNT_W-1:0] countMag;

  always_comb begin
    countNeg = countIn[CNT_W-1];
    countMag = countNeg ? (~countIn + ONE_C) : countIn;
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: ctl.load = start;
      ST_RUN: begin
        if (goRight) begin
          if (remaining == '0) ctl.finish    = 1'b1;
          else                 ctl.stepRight = 1'b1;
        end else if (fracZero) begin
          ctl.finish    = 1'b1;
          ctl.forceZero = 1'b1;
          ctl.markNorm  = 1'b1;
        end else if (fracNorm) begin
          ctl.finish   = 1'b1;
          ctl.markNorm = firstStep;
        end else if (remaining == '0) begin
          ctl.finish = 1'b1;
        end else begin
          ctl.stepLeft = 1'b1;
          ctl.finish   = charZero;  // underflow ends the run with this step
        end
      end
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      goRight   <= 1'b0;
      firstStep <= 1'b0;
      remaining <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctl.load) begin
            state     <= ST_RUN;
            goRight   <= countNeg;
            remaining <= countMag;
            firstStep <= 1'b1;
          end
        end
        ST_RUN: begin
          if (ctl.stepLeft || ctl.stepRight) begin
            remaining <= remaining - ONE_C;
            firstStep <= 1'b0;
          end
          if (ctl.finish) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hfs_datapath.sv
// Holds sign, characteristic, fraction and flags; builds the result word.
module hfs_datapath
  import hfs_pkg::*;
#(
  parameter int CHAR_W       = 7,
  parameter int SHORT_FRAC_W = 24,
  parameter int LONG_FRAC_W  = 56,
  parameter int DIGIT_W      = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  hfsCtrl_t                             ctl,
  input  logic                                 fmtLong,
  input  logic [1+CHAR_W+LONG_FRAC_W-1:0]      operandIn,
  output logic                                 fracZero,
  output logic                                 fracNorm,
  output logic                                 charZero,
  output logic [1+CHAR_W+LONG_FRAC_W-1:0]      resultOut,
  output logic                                 cc1,
  output logic                                 cc2,
  output logic                                 done
);
  localparam int SHORT_W = 1 + CHAR_W + SHORT_FRAC_W;
  localparam int LONG_W  = 1 + CHAR_W + LONG_FRAC_W;
  localparam int PAD_F   = LONG_FRAC_W - SHORT_FRAC_W;
  localparam int PAD_W   = LONG_W - SHORT_W;
  localparam logic [LONG_FRAC_W-1:0] SHORT_MASK = {{PAD_F{1'b0}}, {SHORT_FRAC_W{1'b1}}};
  localparam logic [LONG_FRAC_W-1:0] LONG_MASK  = '1;
  localparam logic [CHAR_W-1:0]      ONE_CH     = CHAR_W'(1);

  logic                    isLong;
  logic                    signR;
  logic [CHAR_W-1:0]       charR;
  logic [LONG_FRAC_W-1:0]  fracR;
  logic                    cc1R, cc2R, doneR;
  logic [LONG_W-1:0]       resultR;

  logic                    shortSign, longSign;
  logic [CHAR_W-1:0]       shortChar, longChar;
  logic [SHORT_FRAC_W-1:0] shortFrac;
  logic [LONG_FRAC_W-1:0]  longFrac;
  logic [SHORT_W-1:0]      shortPacked;
  logic [LONG_W-1:0]       longPacked;

  logic                    selSign;
  logic [CHAR_W-1:0]       selChar;
  logic [LONG_FRAC_W-1:0]  selFrac;
  logic [CHAR_W-1:0]       nextChar;
  logic [LONG_FRAC_W-1:0]  nextFrac;
  logic [LONG_FRAC_W-1:0]  fracShl;
  logic [LONG_FRAC_W-1:0]  fracShr;

  hfs_lane #(.CHAR_W(CHAR_W), .FRAC_W(SHORT_FRAC_W)) u_shortLane (
    .operandIn (operandIn[SHORT_W-1:0]),
    .packChar  (nextChar),
    .packFrac  (nextFrac[SHORT_FRAC_W-1:0]),
    .packNeg   (signR),
    .unpSign   (shortSign),
    .unpChar   (shortChar),
    .unpFrac   (shortFrac),
    .packWord  (shortPacked)
  );

  hfs_lane #(.CHAR_W(CHAR_W), .FRAC_W(LONG_FRAC_W)) u_longLane (
    .operandIn (operandIn),
    .packChar  (nextChar),
    .packFrac  (nextFrac),
    .packNeg   (signR),
    .unpSign   (longSign),
    .unpChar   (longChar),
    .unpFrac   (longFrac),
    .packWord  (longPacked)
  );

  always_comb begin
    selSign = fmtLong ? longSign : shortSign;
    selChar = fmtLong ? longChar : shortChar;
    selFrac = fmtLong ? longFrac : {{PAD_F{1'b0}}, shortFrac};

    fracZero = (fracR == '0);
    fracNorm = isLong ? (|fracR[LONG_FRAC_W-1 -: DIGIT_W])
                      : (|fracR[SHORT_FRAC_W-1 -: DIGIT_W]);
    charZero = (charR == '0);

    fracShl = (fracR << DIGIT_W) & (isLong ? LONG_MASK : SHORT_MASK);
    fracShr = fracR >> DIGIT_W;

    nextChar = charR;
    nextFrac = fracR;
    if (ctl.stepLeft) begin
      nextChar = charR - ONE_CH;
      nextFrac = fracShl;
    end else if (ctl.stepRight) begin
      nextChar = charR + ONE_CH;
      nextFrac = fracShr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isLong  <= 1'b0;
      signR   <= 1'b0;
      charR   <= '0;
      fracR   <= '0;
      cc1R    <= 1'b0;
      cc2R    <= 1'b0;
      doneR   <= 1'b0;
      resultR <= '0;
    end else begin
      doneR <= ctl.finish;
      if (ctl.load) begin
        isLong <= fmtLong;
        signR  <= selSign;
        charR  <= selChar;
        fracR  <= selFrac;
        cc1R   <= 1'b0;
        cc2R   <= 1'b0;
      end else begin
        charR <= nextChar;
        fracR <= nextFrac;
        if (ctl.markNorm) cc1R <= 1'b1;
        if (ctl.stepLeft && charZero) cc2R <= 1'b1;
      end
      if (ctl.finish) begin
        if (ctl.forceZero) resultR <= '0;
        else if (isLong)   resultR <= longPacked;
        else               resultR <= {{PAD_W{1'b0}}, shortPacked};
      end
    end
  end

  assign resultOut = resultR;
  assign cc1       = cc1R;
  assign cc2       = cc2R;
  assign done      = doneR;
endmodule

// File: rtl/hex_fp_shifter.sv
module hex_fp_shifter
  import hfs_pkg::*;
#(
  parameter int CHAR_W       = 7,
  parameter int SHORT_FRAC_W = 24,
  parameter int LONG_FRAC_W  = 56,
  parameter int DIGIT_W      = 4,
  parameter int CNT_W        = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic                              fmtLong,
  input  logic [1+CHAR_W+LONG_FRAC_W-1:0]   operandIn,
  input  logic [CNT_W-1:0]                  countIn,
  output logic [1+CHAR_W+LONG_FRAC_W-1:0]   resultOut,
  output logic                              cc1,
  output logic                              cc2,
  output logic                              done
);
  localparam int SHORT_W = 1 + CHAR_W + SHORT_FRAC_W;
  localparam int LONG_W  = 1 + CHAR_W + LONG_FRAC_W;

  hfsCtrl_t ctl;
  logic     fracZero, fracNorm, charZero;

  hfs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .countIn  (countIn),
    .fracZero (fracZero),
    .fracNorm (fracNorm),
    .charZero (charZero),
    .ctl      (ctl)
  );

  hfs_datapath #(
    .CHAR_W       (CHAR_W),
    .SHORT_FRAC_W (SHORT_FRAC_W),
    .LONG_FRAC_W  (LONG_FRAC_W),
    .DIGIT_W      (DIGIT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .fmtLong   (fmtLong),
    .operandIn (operandIn),
    .fracZero  (fracZero),
    .fracNorm  (fracNorm),
    .charZero  (charZero),
    .resultOut (resultOut),
    .cc1       (cc1),
    .cc2       (cc2),
    .done      (done)
  );
endmodule

// File: rtl/hfs_checker.sv
module hfs_checker #(
  parameter int SHORT_W = 32,
  parameter int LONG_W  = 64,
  parameter int CNT_W   = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              fmtLong,
  input logic [CNT_W-1:0]  countIn,
  input logic [LONG_W-1:0] resultOut,
  input logic              cc1,
  input logic              cc2,
  input logic              done
);
  logic             busyC, rightC, longC, accept;
  logic [CNT_W-1:0] magC;
  logic [CNT_W:0]   cycC;

  assign accept = start && (!busyC || done);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC  <= 1'b0;
      rightC <= 1'b0;
      longC  <= 1'b0;
      magC   <= '0;
      cycC   <= '0;
    end else if (accept) begin
      busyC  <= 1'b1;
      rightC <= countIn[CNT_W-1];
      longC  <= fmtLong;
      magC   <= countIn[CNT_W-1] ? (~countIn + CNT_W'(1)) : countIn;
      cycC   <= '0;
    end else begin
      if (done)  busyC <= 1'b0;
      if (busyC) cycC  <= cycC + (CNT_W+1)'(1);
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_early_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !done);

  assert_right_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && rightC) |-> (cycC == {1'b0, magC} + (CNT_W+1)'(1)));

  assert_left_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !rightC) |-> (cycC >= (CNT_W+1)'(1) && cycC <= {1'b0, magC} + (CNT_W+1)'(1)));

  assert_short_upper_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !longC) |-> (resultOut[LONG_W-1:SHORT_W] == '0));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(cc1 && cc2));

  assert_right_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && rightC) |-> (!cc1 && !cc2));
endmodule

bind hex_fp_shifter hfs_checker #(
  .SHORT_W (SHORT_W),
  .LONG_W  (LONG_W),
  .CNT_W   (CNT_W)
) u_hfsChecker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .fmtLong   (fmtLong),
  .countIn   (countIn),
  .resultOut (resultOut),
  .cc1       (cc1),
  .cc2       (cc2),
  .done      (done)
);

// File: tb/test_hex_fp_shifter.sv
`timescale 1ns/1ps
module test_hex_fp_shifter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        fmtLong = 1'b0;
  logic [63:0] operandIn = '0;
  logic [6:0]  countIn = '0;
  logic [63:0] resultOut;
  logic        cc1, cc2, done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hex_fp_shifter i_hex_fp_shifter (
    .clk(clk), .rstN(rstN), .start(start), .fmtLong(fmtLong),
    .operandIn(operandIn), .countIn(countIn),
    .resultOut(resultOut), .cc1(cc1), .cc2(cc2), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: result, flags and the edge on which done appears
  function automatic void refModel(input bit lng, input logic [63:0] op,
      input logic [6:0] c, output logic [63:0] res, output bit e1,
      output bit e2, output int cyc);
    int fw, ch, n, steps;
    logic [63:0] wmask, fmask, x, fr;
    bit s;
    fw    = lng ? 56 : 24;
    wmask = lng ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    fmask = (64'd1 << fw) - 64'd1;
    x     = op & wmask;
    s     = lng ? x[63] : x[31];
    if (s) x = (~x + 64'd1) & wmask;
    ch    = int'((x >> fw) & 64'h7F);
    fr    = x & fmask;
    n     = int'($signed(c));
    e1 = 1'b0; e2 = 1'b0; steps = 0; res = '0;
    if (n >= 0) begin
      if (fr == 0) begin
        e1 = 1'b1; cyc = 1;
        return;
      end
      if ((fr >> (fw - 4)) != 0) e1 = 1'b1;
      cyc = -1;
      while (cyc < 0) begin
        if ((fr >> (fw - 4)) != 0 || steps == n) cyc = steps + 1;
        else begin
          fr = (fr << 4) & fmask;
          steps++;
          if (ch == 0) begin ch = 127; e2 = 1'b1; cyc = steps; end
          else ch--;
        end
      end
    end else begin
      for (int i = 0; i < -n; i++) begin
        fr = fr >> 4;
        ch = (ch + 1) % 128;
      end
      cyc = 1 - n;
    end
    x = (64'(ch) << fw) | fr;
    if (s) x = (~x + 64'd1) & wmask;
    res = x;
  endfunction

  // one operation; optionally a second start mid-run which must be ignored
  task automatic runOp(input bit lng, input logic [63:0] op, input logic [6:0] c,
                       input string req, input bit interfere);
    logic [63:0] expRes;
    bit e1, e2, timingOk;
    int cyc;
    refModel(lng, op, c, expRes, e1, e2, cyc);
    @(negedge clk);
    start = 1'b1; fmtLong = lng; operandIn = op; countIn = c;
    @(negedge clk);
    start = 1'b0;
    timingOk = (done == 1'b0);
    for (int k = 1; k <= cyc + 4; k++) begin
      @(negedge clk);
      if (done !== (k == cyc)) timingOk = 1'b0;
      if (k == cyc) begin
        check(resultOut === expRes, req, "result", resultOut, expRes);
        check(cc1 === e1, "R4", "cc1", 64'(cc1), 64'(e1));
        check(cc2 === e2, "R7", "cc2", 64'(cc2), 64'(e2));
      end
      start = 1'b0;
      if (interfere && k == 1) begin
        start = 1'b1; fmtLong = ~lng; operandIn = ~op; countIn = 7'h02;
      end
    end
    check(timingOk, interfere ? "R10" : "R9", "done timing", 64'(timingOk), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done === 1'b0 && cc1 === 1'b0 && cc2 === 1'b0, "R11", "flags in reset",
          {61'd0, done, cc1, cc2}, 64'd0);
    check(resultOut === 64'd0, "R11", "result in reset", resultOut, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp(1'b0, 64'h0000_0000_4110_0000, 7'd5,  "R4",  1'b0); // already normalized
    runOp(1'b0, 64'h0000_0000_4200_1234, 7'd5,  "R6",  1'b0); // two steps to normalize
    runOp(1'b0, 64'h0000_0000_4200_1234, 7'd1,  "R6",  1'b0); // count runs out
    runOp(1'b0, 64'h0000_0000_4200_1234, 7'd0,  "R2",  1'b0); // zero count
    runOp(1'b0, 64'h0000_0000_C500_0000, 7'd3,  "R5",  1'b0); // true zero with sign
    runOp(1'b1, 64'h7F00_0000_0000_0000, 7'd9,  "R5",  1'b0); // long true zero
    runOp(1'b0, 64'h0000_0000_0100_0010, 7'd10, "R7",  1'b0); // underflow on 2nd step
    runOp(1'b0, 64'h0000_0000_BEFE_DCC0, 7'd3,  "R3",  1'b0); // negative operand
    runOp(1'b0, 64'h0000_0000_4112_3456, 7'h7D, "R8",  1'b0); // right by 3
    runOp(1'b0, 64'h0000_0000_7F12_3456, 7'h7F, "R8",  1'b0); // right, char wraps
    runOp(1'b0, 64'hFFFF_FFFF_4200_1234, 7'd5,  "R1",  1'b0); // upper half ignored
    runOp(1'b1, 64'h4000_0000_0000_0123, 7'd20, "R1",  1'b0); // long, 11 steps
    runOp(1'b1, 64'h4112_3456_789A_BCDE, 7'h40, "R2",  1'b0); // right by 64
    runOp(1'b1, 64'h8000_0000_0000_0001, 7'd63, "R3",  1'b0); // long negative
    runOp(1'b0, 64'h0000_0000_4200_0012, 7'd6,  "R10", 1'b1); // start mid-run

    for (int t = 0; t < 60; t++) begin
      logic [63:0] op;
      logic [6:0]  c;
      op = {$urandom(), $urandom()};
      if (t % 3 == 0) op = op & 64'hFF00_0000_0000_0FFF;
      c  = 7'($urandom_range(0, 127));
      runOp(t[0], op, c, c[6] ? "R8" : "R6", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule